// File: doc/BRIEF.md
# Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a small table of per-branch state. A slice of the program counter selects one entry of the table. The front end presents a lookup address and reads back a predict-taken bit in the same cycle, with no register in the read path. When a branch resolves, the back end sends its address and its actual direction on a strobed update port. The selected entry then learns from that outcome at the next clock edge.

A static parameter picks one of two learning schemes. In the saturating scheme each entry is a two-bit up/down counter. Because of this hysteresis, one surprise from a strong state does not reverse the guess. In the voting scheme each entry is a three-bit record of the most recent outcomes, and the guess follows the majority of those three.

Top module: `bdp_predictor`

## Requirements
- R1: After reset, every entry predicts not taken. A saturating entry starts at state 01 and a voting entry starts at 000.
- R2: The entry index is the group of PC bits starting just above the ALIGN low alignment bits, log2(ENTRIES) bits wide. Addresses that differ only outside that group share one entry.
- R3: When a lookup and an update select the same entry in one cycle, the lookup returns the prediction from before the update.
- R4: Saturating scheme: states 00 and 01 predict not taken, and states 10 and 11 predict taken. A taken outcome adds one to the state, which stops at 11.
- R5: Saturating scheme: a not-taken outcome subtracts one from the state, which stops at 00.
- R6: Saturating scheme: a single outcome against a strong state (11 or 00) does not change the prediction.
- R7: Voting scheme: the prediction is taken exactly when two or more of the last three recorded outcomes were taken.
- R8: Voting scheme: each update shifts the new outcome in as the newest of the three and drops the oldest.
- R9: An update changes only the entry it selects. All other entries keep their predictions.
- R10: In both schemes, after two back-to-back updates of one entry with the same outcome, that entry predicts that outcome.
- R11: With the update strobe low, the table does not change, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | PC_W | Address of the branch being looked up |
| lk_taken | output | 1 | Prediction for lk_pc, 1 = taken |
| up_valid | input | 1 | Strobe: a resolved branch is presented this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual direction of the resolved branch, 1 = taken |

## Verification
The hardest case to reach from the ports is an entry that is updated and looked up in the same cycle. That case must also straddle a change in the prediction, such as a saturating entry moving from 01 to 10, or a voting record picking up its second taken outcome. The stimulus drives the lookup at the very entry being trained on every step of a directed walk, so the old value shows up just at the flip. It also sends updates through aliased addresses that differ only in high and alignment bits. A long pseudo-random run over eight entries then keeps updates and lookups colliding often.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

    typedef enum logic {
        SCH_SAT2  = 1'b0,
        SCH_VOTE3 = 1'b1
    } scheme_e;

    function automatic int state_width(scheme_e s);
        return (s == SCH_SAT2) ? 2 : 3;
    endfunction

endpackage

// File: rtl/bdp_index.sv
module bdp_index #(
    parameter int PC_W  = 32,
    parameter int IDXW  = 6,
    parameter int ALIGN = 2
) (
    input  logic [PC_W-1:0] pc,
    output logic [IDXW-1:0] idx
);
    logic unused_pc_parity;

    assign idx              = pc[ALIGN +: IDXW];
    assign unused_pc_parity = ^pc;
endmodule

// File: rtl/bdp_next.sv
module bdp_next
    import bdp_pkg::*;
#(
    parameter scheme_e SCHEME = SCH_SAT2,
    parameter int      SW     = 2
) (
    input  logic [SW-1:0] cur,
    input  logic          taken,
    output logic [SW-1:0] nxt
);
    generate
        if (SCHEME == SCH_SAT2) begin : g_sat
            localparam logic [SW-1:0] TOP = '1;
            localparam logic [SW-1:0] BOT = '0;
            always_comb begin
                nxt = cur;
                if (taken && cur != TOP) begin
                    nxt = cur + SW'(1);
                end else if (!taken && cur != BOT) begin
                    nxt = cur - SW'(1);
                end
            end
        end else begin : g_vote
            always_comb begin
                nxt = {cur[SW-2:0], taken};
            end
        end
    endgenerate
endmodule

// File: rtl/bdp_decide.sv
module bdp_decide
    import bdp_pkg::*;
#(
    parameter scheme_e SCHEME = SCH_SAT2,
    parameter int      SW     = 2
) (
    input  logic [SW-1:0] st,
    output logic          taken
);
    generate
        if (SCHEME == SCH_SAT2) begin : g_sat
            assign taken = st[SW-1];
        end else begin : g_vote
            assign taken = (st[0] & st[1]) | (st[0] & st[2]) | (st[1] & st[2]);
        end
    endgenerate
endmodule

// File: rtl/bdp_predictor.sv
module bdp_predictor
    import bdp_pkg::*;
#(
    parameter int      PC_W    = 32,
    parameter int      ENTRIES = 64,
    parameter int      ALIGN   = 2,
    parameter scheme_e SCHEME  = SCH_SAT2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken
);
    localparam int            IDXW  = $clog2(ENTRIES);
    localparam int            SW    = state_width(SCHEME);
    localparam logic [SW-1:0] RST_V = (SCHEME == SCH_SAT2) ? SW'(1) : SW'(0);

    typedef struct packed {
        logic [ENTRIES-1:0][SW-1:0] tbl;
    } st_t;

    st_t s_d, s_q;

    logic [IDXW-1:0]            lk_idx, up_idx;
    logic [SW-1:0]              lk_cur, up_cur, up_nxt;
    logic [ENTRIES-1:0][SW-1:0] tbl_q;

    bdp_index #(.PC_W(PC_W), .IDXW(IDXW), .ALIGN(ALIGN)) u_lk_ix (
        .pc (lk_pc),
        .idx(lk_idx)
    );

    bdp_index #(.PC_W(PC_W), .IDXW(IDXW), .ALIGN(ALIGN)) u_up_ix (
        .pc (up_pc),
        .idx(up_idx)
    );

    assign lk_cur = s_q.tbl[lk_idx];
    assign up_cur = s_q.tbl[up_idx];
    assign tbl_q  = s_q.tbl;

    bdp_next #(.SCHEME(SCHEME), .SW(SW)) u_next (
        .cur  (up_cur),
        .taken(up_taken),
        .nxt  (up_nxt)
    );

    bdp_decide #(.SCHEME(SCHEME), .SW(SW)) u_decide (
        .st   (lk_cur),
        .taken(lk_taken)
    );

    always_comb begin
        s_d = s_q;
        if (up_valid) begin
            s_d.tbl[up_idx] = up_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.tbl <= {ENTRIES{RST_V}};
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/bdp_checker.sv
module bdp_checker
    import bdp_pkg::*;
#(
    parameter int      PC_W    = 32,
    parameter int      ENTRIES = 64,
    parameter int      ALIGN   = 2,
    parameter scheme_e SCHEME  = SCH_SAT2
) (
    input logic                                       clk,
    input logic                                       rst_n,
    input logic [PC_W-1:0]                            lk_pc,
    input logic                                       lk_taken,
    input logic                                       up_valid,
    input logic [PC_W-1:0]                            up_pc,
    input logic                                       up_taken,
    input logic [ENTRIES-1:0][state_width(SCHEME)-1:0] tbl_q
);
    localparam int IDXW = $clog2(ENTRIES);
    localparam int SW   = state_width(SCHEME);

    logic [IDXW-1:0]            lk_idx, up_idx, prev_idx_q;
    logic                       prev_tk_q, prev_nt_q;
    logic [ENTRIES-1:0][SW-1:0] old_q;
    logic [ENTRIES-1:0]         chg;

    assign lk_idx = lk_pc[ALIGN +: IDXW];
    assign up_idx = up_pc[ALIGN +: IDXW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_tk_q  <= 1'b0;
            prev_nt_q  <= 1'b0;
            prev_idx_q <= '0;
        end else begin
            prev_tk_q  <= up_valid && up_taken;
            prev_nt_q  <= up_valid && !up_taken;
            prev_idx_q <= up_idx;
        end
    end

    always_ff @(posedge clk) begin
        old_q <= tbl_q;
    end

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            chg[i] = (tbl_q[i] != old_q[i]);
        end
    end

    a_r1_reset_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !lk_taken);

    a_r10_two_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_tk_q && up_valid && up_taken && prev_idx_q == up_idx)
        |=> (lk_idx != $past(up_idx) || lk_taken));

    a_r10_two_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_nt_q && up_valid && !up_taken && prev_idx_q == up_idx)
        |=> (lk_idx != $past(up_idx) || !lk_taken));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(tbl_q));

    a_r9_single_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $onehot0(chg));

    generate
        if (SCHEME == SCH_SAT2) begin : g_sat
            a_r6_strong_taken_holds: assert property (@(posedge clk) disable iff (!rst_n)
                (up_valid && !up_taken && tbl_q[up_idx] == SW'(3))
                |=> tbl_q[$past(up_idx)] == SW'(2));
            a_r4_top_saturates: assert property (@(posedge clk) disable iff (!rst_n)
                (up_valid && up_taken && tbl_q[up_idx] == SW'(3))
                |=> tbl_q[$past(up_idx)] == SW'(3));
        end else begin : g_vote
            a_r8_newest_in: assert property (@(posedge clk) disable iff (!rst_n)
                up_valid |=> tbl_q[$past(up_idx)][0] == $past(up_taken));
        end
    endgenerate
endmodule

bind bdp_predictor bdp_checker #(
    .PC_W(PC_W), .ENTRIES(ENTRIES), .ALIGN(ALIGN), .SCHEME(SCHEME)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_pc   (lk_pc),
    .lk_taken(lk_taken),
    .up_valid(up_valid),
    .up_pc   (up_pc),
    .up_taken(up_taken),
    .tbl_q   (tbl_q)
);

// File: tb/bdp_predictor_tb.sv
module bdp_predictor_tb;
    import bdp_pkg::*;

    localparam int CLK_NS  = 10;
    localparam int PC_W    = 32;
    localparam int ENTRIES = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic [PC_W-1:0] up_pc = '0;
    logic            up_valid = 1'b0;
    logic            up_taken = 1'b0;
    logic            p_sat, p_vote;

    always #(CLK_NS/2) clk = ~clk;

    bdp_predictor #(.PC_W(PC_W), .ENTRIES(ENTRIES), .ALIGN(2), .SCHEME(SCH_SAT2)) u_dut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(p_sat),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
    );

    bdp_predictor #(.PC_W(PC_W), .ENTRIES(ENTRIES), .ALIGN(2), .SCHEME(SCH_VOTE3)) u_dut_hist (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(p_vote),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
    );

    typedef struct {
        logic [PC_W-1:0] pc;
        bit              e_sat;
        bit              e_vote;
        string           tag;
    } exp_t;

    exp_t       sb[$];
    int         cnt_m[ENTRIES];
    logic [2:0] his_m[ENTRIES];
    int         checks = 0;
    int         errors = 0;

    function automatic int ix(logic [PC_W-1:0] pc);
        return int'(pc[7:2]);
    endfunction

    function automatic logic [PC_W-1:0] pc_of(int idx, logic [23:0] hi, logic [1:0] lo);
        return {hi, idx[5:0], lo};
    endfunction

    // Driver: drives one cycle, pushes expected prediction (pre-update state), then trains the model.
    task automatic step(bit v, logic [PC_W-1:0] upc, bit t, logic [PC_W-1:0] lpc, string tag);
        exp_t e;
        int   u;
        @(negedge clk);
        up_valid = v;
        up_pc    = upc;
        up_taken = t;
        lk_pc    = lpc;
        e.pc     = lpc;
        e.e_sat  = cnt_m[ix(lpc)] >= 2;
        e.e_vote = $countones(his_m[ix(lpc)]) >= 2;
        e.tag    = tag;
        sb.push_back(e);
        if (v) begin
            u = ix(upc);
            if (t && cnt_m[u] < 3) cnt_m[u]++;
            else if (!t && cnt_m[u] > 0) cnt_m[u]--;
            his_m[u] = {his_m[u][1:0], t};
        end
    endtask

    // Monitor: compares outputs shortly after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (p_sat !== e.e_sat) begin
                    errors++;
                    $display("FAIL %s saturating pc=%h actual=%0b expected=%0b", e.tag, e.pc, p_sat, e.e_sat);
                end
                checks++;
                if (p_vote !== e.e_vote) begin
                    errors++;
                    $display("FAIL %s voting pc=%h actual=%0b expected=%0b", e.tag, e.pc, p_vote, e.e_vote);
                end
            end
        end
    end

    initial begin
        #(CLK_NS * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < ENTRIES; i++) begin
            cnt_m[i] = 1;
            his_m[i] = 3'b000;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state across the table
        step(0, '0, 0, pc_of(0, 24'h0, 2'b00), "R1");
        step(0, '0, 0, pc_of(5, 24'h0, 2'b00), "R1");
        step(0, '0, 0, pc_of(63, 24'hFFFFFF, 2'b00), "R1");

        // R11: strobe low, taken presented repeatedly
        for (int k = 0; k < 4; k++) step(0, pc_of(9, 24'h0, 2'b00), 1, pc_of(9, 24'h0, 2'b00), "R11");
        step(0, '0, 0, pc_of(9, 24'h0, 2'b00), "R11");

        // R3 R4 R7 R10: taken walk on entry 3, looked up in the same cycle
        for (int k = 0; k < 5; k++) step(1, pc_of(3, 24'h0, 2'b00), 1, pc_of(3, 24'h0, 2'b00), "R3 R4 R7 R10");
        step(0, '0, 0, pc_of(3, 24'h0, 2'b00), "R4 saturated top");
        // R6: one not-taken from strong taken keeps taken
        step(1, pc_of(3, 24'h0, 2'b00), 0, pc_of(3, 24'h0, 2'b00), "R6 R8");
        step(0, '0, 0, pc_of(3, 24'h0, 2'b00), "R6 R8");
        // R5: walk down and saturate
        for (int k = 0; k < 5; k++) step(1, pc_of(3, 24'h0, 2'b00), 0, pc_of(3, 24'h0, 2'b00), "R5 R10");
        step(1, pc_of(3, 24'h0, 2'b00), 1, pc_of(3, 24'h0, 2'b00), "R5 R6");
        step(0, '0, 0, pc_of(3, 24'h0, 2'b00), "R6 single taken from 00");

        // R7 R8: alternating pattern on entry 7
        step(1, pc_of(7, 24'h0, 2'b00), 1, pc_of(7, 24'h0, 2'b00), "R7");
        step(1, pc_of(7, 24'h0, 2'b00), 0, pc_of(7, 24'h0, 2'b00), "R7");
        step(1, pc_of(7, 24'h0, 2'b00), 1, pc_of(7, 24'h0, 2'b00), "R7 R8");
        step(1, pc_of(7, 24'h0, 2'b00), 0, pc_of(7, 24'h0, 2'b00), "R7 R8");
        step(1, pc_of(7, 24'h0, 2'b00), 0, pc_of(7, 24'h0, 2'b00), "R8");
        step(0, '0, 0, pc_of(7, 24'h0, 2'b00), "R8 oldest dropped");

        // R2: aliasing through high and alignment bits
        step(1, pc_of(5, 24'hABCDEF, 2'b11), 1, pc_of(5, 24'h000000, 2'b00), "R2");
        step(1, pc_of(5, 24'h123456, 2'b01), 1, pc_of(5, 24'h777777, 2'b10), "R2");
        step(0, '0, 0, pc_of(5, 24'h000001, 2'b00), "R2");

        // R9: hammering entry 8 leaves 9 and 7 alone
        for (int k = 0; k < 4; k++) step(1, pc_of(8, 24'h0, 2'b00), 1, pc_of(9, 24'h0, 2'b00), "R9");
        step(0, '0, 0, pc_of(7, 24'h0, 2'b00), "R9");

        // Mixed pseudo-random traffic on a few colliding entries
        for (int k = 0; k < 3000; k++) begin
            int ui, li;
            ui = int'($urandom_range(0, 7));
            li = ($urandom_range(0, 3) == 0) ? ui : int'($urandom_range(0, 7));
            step(($urandom_range(0, 4) != 0), pc_of(ui, 24'($urandom), 2'($urandom)),
                 $urandom_range(0, 1) == 1, pc_of(li, 24'($urandom), 2'($urandom)),
                 "R3 R4 R5 R7 R9 R11 random");
        end

        @(negedge clk);
        up_valid = 1'b0;
        @(negedge clk);
        #4;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule